// File: doc/BRIEF.md
# Bus Idle and Wait-State Sequencer

This block sits between a CPU access request port and an external memory bus split into chip-select areas 0 to 6. A request carries an area number and a direction. When the sequencer is free it accepts the request, may insert idle cycles, and then drives one bus cycle. During that cycle it asserts that area's chip select and either the read strobe or the write strobe. It ends the cycle with a one-cycle done pulse.

Two 16-bit configuration registers set the timing. Software reads and writes them through a simple port.
- The wait register gives each area the number of wait cycles that stretch its bus cycle.
- The idle register gives each area the number of idle cycles to insert when the bus changes area or changes direction. It also holds a select bit that lets an external WAIT input extend a cycle. WAIT is sampled on the falling clock edge.

A power-on reset restores both registers. A manual reset only clears the sequencer and its access history.

Top module: `bus_cycle_seq`

## Requirements
- R1: After power-on reset `rst_n`, the following hold:
  - The wait register reads 0xFFFF.
  - The idle register reads 0x3FF3.
  - `req_ready` is 1, and all of `cs_n`, `rd_n` and `wr_n` are high.
- R2: The wait register (`reg_addr`=0) is laid out as follows: area 6 in bits [15:13], area 5 in [12:10], area 4 in [9:7], area 3 in [6:5], area 2 in [4:3] and area 0 in [2:0]. A bus cycle to an area holds its strobe for field+1 cycles when WAIT does not extend it. Area 1 has no field and uses 0 wait cycles. Chip select and strobe stay stable until done.
- R3: The idle register (`reg_addr`=1) holds, for area n in {0,2,3,4,5,6}, a 2-bit code at bits [2n+1:2n]. The codes decode as 00→1, 01→1, 10→2 and 11→3 idle cycles, and the code of the new access's area is used. Area 1 always uses 1 idle cycle. No strobe is active during idle cycles.
- R4: Bits 14, 3 and 2 of the idle register always read 0, and writes to them are ignored.
- R5: Idle cycles are inserted only when the new access's area differs from the previous one, or its direction differs. A repeated access to the same area in the same direction starts with no idle cycle.
- R6: The first access after power-on reset starts with no idle cycle.
- R7: Bit 15 of the idle register is the WAIT select bit.
  - When it is 1, a cycle whose programmed waits are used up stays in the bus cycle while `ext_wait`, sampled on the falling clock edge inside that clock cycle, is 1.
  - While the programmed waits run, `ext_wait` has no effect.
  - When the bit is 0, `ext_wait` is ignored.
- R8: A manual reset (`man_rst_n`=0 at a rising edge) returns the sequencer to idle and clears the access history, so the next access has no idle cycle. Both registers keep their values.
- R9: A request is accepted only in a cycle where `req_ready` is 1, and `req_ready` drops in the cycle after the acceptance. Requests presented while busy are dropped and do not change the access history.
- R10: During a bus cycle exactly one `cs_n` bit (that of the area) is low. `rd_n` is low for reads (`req_write`=0) and `wr_n` is low for writes. `done` is high for exactly the last strobe cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset, released synchronously |
| man_rst_n | input | 1 | Synchronous active-low manual reset of the sequencer |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 wait register, 1 idle register |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the selected register |
| req_valid | input | 1 | Access request |
| req_area | input | 3 | Target area of the request (0 to 6) |
| req_write | input | 1 | Request direction: 1 write, 0 read |
| req_ready | output | 1 | Sequencer free; request accepted at the next rising edge |
| ext_wait | input | 1 | External wait request, active high |
| cs_n | output | 7 | Active-low chip select per area |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| done | output | 1 | One-cycle pulse in the last cycle of a bus cycle |

## Verification
The bench builds the block with its defaults: seven areas, 3-bit counters and a two-stage reset synchronizer. With these values every field width of the wait register is reachable, including the largest 3-bit value of 7 waits. All four idle codes can be reached with their distinct lengths of 1, 2 and 3 idle cycles. The bench exercises WAIT extensions both shorter and longer than the programmed waits, and requests dropped while the sequencer is busy, against a per-clock reference model.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  localparam int CFG_W = 16;

  localparam logic [CFG_W-1:0] WAIT_RST_VAL  = 16'hFFFF;
  localparam logic [CFG_W-1:0] IDLE_RST_VAL  = 16'h3FF3;
  localparam logic [CFG_W-1:0] IDLE_WR_MASK  = 16'hBFF3;
  localparam int               WAIT_SEL_BIT  = 15;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GAP  = 2'd1,
    ST_BUS  = 2'd2
  } seq_state_e;

  // Wait count of an area taken from the wait register; areas without a
  // field give zero.
  function automatic logic [2:0] wait_field(input logic [CFG_W-1:0] wreg,
                                            input int area);
    logic [2:0] val;
    case (area)
      0:       val = wreg[2:0];
      2:       val = {1'b0, wreg[4:3]};
      3:       val = {1'b0, wreg[6:5]};
      4:       val = wreg[9:7];
      5:       val = wreg[12:10];
      6:       val = wreg[15:13];
      default: val = 3'd0;
    endcase
    return val;
  endfunction

  // Idle code of an area from the idle register; areas without a field
  // give the code that means one idle cycle.
  function automatic logic [1:0] idle_code(input logic [CFG_W-1:0] ireg,
                                           input int area);
    logic [1:0] code;
    case (area)
      0:       code = ireg[1:0];
      2:       code = ireg[5:4];
      3:       code = ireg[7:6];
      4:       code = ireg[9:8];
      5:       code = ireg[11:10];
      6:       code = ireg[13:12];
      default: code = 2'b00;
    endcase
    return code;
  endfunction

  function automatic logic [2:0] idle_count(input logic [1:0] code);
    logic [2:0] n;
    case (code)
      2'b10:   n = 3'd2;
      2'b11:   n = 3'd3;
      default: n = 3'd1;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/bcs_rst_sync.sv
module bcs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      assign sync_d = 1'b1;
    end else begin : g_chain
      assign sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/bcs_wait_sampler.sv
module bcs_wait_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic wait_in,
  output logic wait_smp
);

  logic smp_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= 1'b0;
    end else begin
      smp_q <= wait_in;
    end
  end

  assign wait_smp = smp_q;

endmodule

// File: rtl/bcs_cfg_regs.sv
module bcs_cfg_regs
  import bcs_pkg::*;
#(
  parameter int NUM_AREAS = 7,
  parameter int AREA_W    = 3,
  parameter int CNT_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_addr,
  input  logic [CFG_W-1:0]  reg_wdata,
  output logic [CFG_W-1:0]  reg_rdata,
  input  logic [AREA_W-1:0] lk_area,
  output logic [CNT_W-1:0]  lk_wait,
  output logic [CNT_W-1:0]  lk_idle,
  output logic              wait_sel
);

  localparam int LUT_N = 1 << AREA_W;

  logic [CFG_W-1:0] wait_q, wait_d;
  logic [CFG_W-1:0] idle_q, idle_d;
  logic             wait_en, idle_en;

  logic [CNT_W-1:0] wait_tab [LUT_N];
  logic [CNT_W-1:0] idle_tab [LUT_N];

  // write decode and next values
  always_comb begin
    wait_en = reg_we && !reg_addr;
    idle_en = reg_we &&  reg_addr;
    wait_d  = reg_wdata;
    idle_d  = reg_wdata & IDLE_WR_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= WAIT_RST_VAL;
      idle_q <= IDLE_RST_VAL;
    end else begin
      if (wait_en) begin
        wait_q <= wait_d;
      end
      if (idle_en) begin
        idle_q <= idle_d;
      end
    end
  end

  // per-area decode tables; codes beyond the populated areas behave as an
  // area without fields
  generate
    for (genvar a = 0; a < LUT_N; a++) begin : g_area
      if (a < NUM_AREAS) begin : g_live
        assign wait_tab[a] = CNT_W'(wait_field(wait_q, a));
        assign idle_tab[a] = CNT_W'(idle_count(idle_code(idle_q, a)));
      end else begin : g_none
        assign wait_tab[a] = '0;
        assign idle_tab[a] = CNT_W'(1);
      end
    end
  endgenerate

  assign lk_wait   = wait_tab[lk_area];
  assign lk_idle   = idle_tab[lk_area];
  assign wait_sel  = idle_q[WAIT_SEL_BIT];
  assign reg_rdata = reg_addr ? idle_q : wait_q;

endmodule

// File: rtl/bcs_seq_fsm.sv
module bcs_seq_fsm
  import bcs_pkg::*;
#(
  parameter int AREA_W = 3,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              man_rst_n,
  input  logic              req_valid,
  input  logic [AREA_W-1:0] req_area,
  input  logic              req_write,
  input  logic [CNT_W-1:0]  lk_wait,
  input  logic [CNT_W-1:0]  lk_idle,
  input  logic              wait_hold,
  output logic              req_ready,
  output logic              bus_active,
  output logic [AREA_W-1:0] bus_area,
  output logic              bus_write,
  output logic              done
);

  seq_state_e        state_q, state_d;
  logic [CNT_W-1:0]  gap_q, gap_d;
  logic [CNT_W-1:0]  wcnt_q, wcnt_d;
  logic [AREA_W-1:0] area_q;
  logic              write_q;
  logic              hist_v_q, hist_v_d;
  logic [AREA_W-1:0] hist_area_q;
  logic              hist_wr_q;

  logic accept;
  logic need_gap;
  logic wait_zero;
  logic gap_zero;
  logic cap_en;
  logic gap_en;
  logic wcnt_en;

  always_comb begin
    accept    = (state_q == ST_IDLE) && req_valid && man_rst_n;
    need_gap  = hist_v_q &&
                ((req_area != hist_area_q) || (req_write != hist_wr_q));
    wait_zero = (wcnt_q == '0);
    gap_zero  = (gap_q == '0);
  end

  // next-state logic
  always_comb begin
    state_d  = state_q;
    gap_d    = gap_q;
    wcnt_d   = wcnt_q;
    hist_v_d = hist_v_q;
    cap_en   = 1'b0;
    gap_en   = 1'b0;
    wcnt_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          cap_en   = 1'b1;
          wcnt_en  = 1'b1;
          wcnt_d   = lk_wait;
          hist_v_d = 1'b1;
          if (need_gap) begin
            state_d = ST_GAP;
            gap_en  = 1'b1;
            gap_d   = lk_idle - CNT_W'(1);
          end else begin
            state_d = ST_BUS;
          end
        end
      end
      ST_GAP: begin
        if (gap_zero) begin
          state_d = ST_BUS;
        end else begin
          gap_en = 1'b1;
          gap_d  = gap_q - CNT_W'(1);
        end
      end
      ST_BUS: begin
        if (!wait_zero) begin
          wcnt_en = 1'b1;
          wcnt_d  = wcnt_q - CNT_W'(1);
        end else if (!wait_hold) begin
          state_d = ST_IDLE;
        end
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
    if (!man_rst_n) begin
      state_d  = ST_IDLE;
      hist_v_d = 1'b0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      gap_q       <= '0;
      wcnt_q      <= '0;
      area_q      <= '0;
      write_q     <= 1'b0;
      hist_v_q    <= 1'b0;
      hist_area_q <= '0;
      hist_wr_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      hist_v_q <= hist_v_d;
      if (gap_en) begin
        gap_q <= gap_d;
      end
      if (wcnt_en) begin
        wcnt_q <= wcnt_d;
      end
      if (cap_en) begin
        area_q      <= req_area;
        write_q     <= req_write;
        hist_area_q <= req_area;
        hist_wr_q   <= req_write;
      end
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign bus_active = (state_q == ST_BUS);
  assign bus_area   = area_q;
  assign bus_write  = write_q;
  assign done       = (state_q == ST_BUS) && wait_zero && !wait_hold;

endmodule

// File: rtl/bcs_strobe_gen.sv
module bcs_strobe_gen #(
  parameter int NUM_AREAS = 7,
  parameter int AREA_W    = 3
) (
  input  logic                 bus_active,
  input  logic [AREA_W-1:0]    bus_area,
  input  logic                 bus_write,
  output logic [NUM_AREAS-1:0] cs_n,
  output logic                 rd_n,
  output logic                 wr_n
);

  generate
    for (genvar i = 0; i < NUM_AREAS; i++) begin : g_cs
      assign cs_n[i] = !(bus_active && (bus_area == AREA_W'(i)));
    end
  endgenerate

  assign rd_n = !(bus_active && !bus_write);
  assign wr_n = !(bus_active &&  bus_write);

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bcs_pkg::*;
#(
  parameter int NUM_AREAS   = 7,
  parameter int CNT_W       = 3,
  parameter int SYNC_STAGES = 2,
  localparam int AREA_W     = $clog2(NUM_AREAS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 man_rst_n,
  input  logic                 reg_we,
  input  logic                 reg_addr,
  input  logic [CFG_W-1:0]     reg_wdata,
  output logic [CFG_W-1:0]     reg_rdata,
  input  logic                 req_valid,
  input  logic [AREA_W-1:0]    req_area,
  input  logic                 req_write,
  output logic                 req_ready,
  input  logic                 ext_wait,
  output logic [NUM_AREAS-1:0] cs_n,
  output logic                 rd_n,
  output logic                 wr_n,
  output logic                 done
);

  logic              rst_int_n;
  logic [CNT_W-1:0]  lk_wait;
  logic [CNT_W-1:0]  lk_idle;
  logic              wait_sel;
  logic              wait_smp;
  logic              wait_hold;
  logic              bus_active;
  logic [AREA_W-1:0] bus_area;
  logic              bus_write;

  bcs_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_int_n)
  );

  bcs_cfg_regs #(
    .NUM_AREAS (NUM_AREAS),
    .AREA_W    (AREA_W),
    .CNT_W     (CNT_W)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .lk_area   (req_area),
    .lk_wait   (lk_wait),
    .lk_idle   (lk_idle),
    .wait_sel  (wait_sel)
  );

  bcs_wait_sampler u_wait (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wait_in  (ext_wait),
    .wait_smp (wait_smp)
  );

  assign wait_hold = wait_sel && wait_smp;

  bcs_seq_fsm #(
    .AREA_W (AREA_W),
    .CNT_W  (CNT_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .man_rst_n  (man_rst_n),
    .req_valid  (req_valid),
    .req_area   (req_area),
    .req_write  (req_write),
    .lk_wait    (lk_wait),
    .lk_idle    (lk_idle),
    .wait_hold  (wait_hold),
    .req_ready  (req_ready),
    .bus_active (bus_active),
    .bus_area   (bus_area),
    .bus_write  (bus_write),
    .done       (done)
  );

  bcs_strobe_gen #(
    .NUM_AREAS (NUM_AREAS),
    .AREA_W    (AREA_W)
  ) u_strobe (
    .bus_active (bus_active),
    .bus_area   (bus_area),
    .bus_write  (bus_write),
    .cs_n       (cs_n),
    .rd_n       (rd_n),
    .wr_n       (wr_n)
  );

endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
  parameter int NUM_AREAS = 7
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 man_rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic                 reg_addr,
  input logic [15:0]          reg_rdata,
  input logic [NUM_AREAS-1:0] cs_n,
  input logic                 rd_n,
  input logic                 wr_n,
  input logic                 done,
  input logic                 bus_active
);

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n)); // R10

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n)); // R10

  AST_DONE_HAS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((rd_n != wr_n) && ($countones(~cs_n) == 1))); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_valid && man_rst_n) |=> !req_ready); // R9

  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid) |=> req_ready); // R9

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_active && !done && man_rst_n) |=>
      (bus_active && $stable(cs_n) && $stable(rd_n) && $stable(wr_n))); // R2

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr |-> ((reg_rdata & 16'h400C) == 16'h0000)); // R4

endmodule

bind bus_cycle_seq bcs_checker #(.NUM_AREAS(NUM_AREAS)) i_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .man_rst_n  (man_rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .reg_addr   (reg_addr),
  .reg_rdata  (reg_rdata),
  .cs_n       (cs_n),
  .rd_n       (rd_n),
  .wr_n       (wr_n),
  .done       (done),
  .bus_active (bus_active)
);

// File: tb/test_bus_cycle_seq.sv
`timescale 1ns/1ps
module test_bus_cycle_seq;

  logic        clk;
  logic        rst_n;
  logic        man_rst_n;
  logic        reg_we;
  logic        reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        req_valid;
  logic [2:0]  req_area;
  logic        req_write;
  logic        req_ready;
  logic        ext_wait;
  logic [6:0]  cs_n;
  logic        rd_n;
  logic        wr_n;
  logic        done;

  int checks;
  int fails;
  bit finished;
  bit cmp_en;

  // reference model state
  int          m_ph;     // 0 free, 1 idle cycles, 2 strobe cycles
  int          m_gl;
  int          m_wl;
  int          m_area;
  int          m_wr;
  int          m_hist;
  int          m_parea;
  int          m_pwr;
  logic [15:0] m_wreg;
  logic [15:0] m_ireg;
  int          m_g;

  bus_cycle_seq i_bus_cycle_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .man_rst_n (man_rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .req_valid (req_valid),
    .req_area  (req_area),
    .req_write (req_write),
    .req_ready (req_ready),
    .ext_wait  (ext_wait),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .done      (done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int exp_waits(input int area, input logic [15:0] w);
    case (area)
      0: return int'(w[2:0]);
      2: return int'(w[4:3]);
      3: return int'(w[6:5]);
      4: return int'(w[9:7]);
      5: return int'(w[12:10]);
      6: return int'(w[15:13]);
      default: return 0;
    endcase
  endfunction

  function automatic int exp_idles(input int area, input logic [15:0] r);
    int code;
    if (area == 1 || area > 6) return 1;
    code = int'((r >> (2 * area)) & 16'h3);
    return (code < 2) ? 1 : code;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // reference model, advanced on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_gl = 0; m_wl = 0; m_area = 0; m_wr = 0;
      m_hist = 0; m_parea = 0; m_pwr = 0;
      m_wreg = 16'hFFFF; m_ireg = 16'h3FF3;
    end else begin
      if (!man_rst_n) begin
        m_ph = 0;
        m_hist = 0;
      end else begin
        case (m_ph)
          0: if (req_valid) begin
               m_area = int'(req_area);
               m_wr   = int'(req_write);
               m_g = (m_hist != 0 && (m_area != m_parea || m_wr != m_pwr)) ?
                     exp_idles(m_area, m_ireg) : 0;
               m_hist = 1; m_parea = m_area; m_pwr = m_wr;
               m_wl = exp_waits(m_area, m_wreg);
               if (m_g > 0) begin m_ph = 1; m_gl = m_g; end
               else m_ph = 2;
             end
          1: begin
               m_gl--;
               if (m_gl == 0) m_ph = 2;
             end
          default: begin
               if (m_wl > 0) m_wl--;
               else if (!(m_ireg[15] && ext_wait)) m_ph = 0;
             end
        endcase
      end
      if (reg_we) begin
        if (reg_addr) m_ireg = reg_wdata & 16'hBFF3;
        else          m_wreg = reg_wdata;
      end
    end
  end

  // per-cycle comparison late in each cycle, after the falling edge
  always @(posedge clk) begin
    #6;
    if (cmp_en && !finished) begin
      int ecs;
      bit in_bus;
      in_bus = (m_ph == 2);
      ecs = 7'h7F;
      if (in_bus && m_area < 7) ecs = ecs & ~(1 << m_area);
      chk("R9", "req_ready", int'(req_ready), (m_ph == 0) ? 1 : 0);
      chk("R10", "cs_n", int'(cs_n), ecs);
      chk("R10", "rd_n", int'(rd_n), (in_bus && m_wr == 0) ? 0 : 1);
      chk("R10", "wr_n", int'(wr_n), (in_bus && m_wr == 1) ? 0 : 1);
      chk(m_ireg[15] ? "R7" : "R2", "done", int'(done),
          (in_bus && m_wl == 0 && !(m_ireg[15] && ext_wait)) ? 1 : 0);
      chk(reg_addr ? "R4" : "R2", "reg_rdata", int'(reg_rdata),
          int'(reg_addr ? m_ireg : m_wreg));
    end
  end

  task automatic wr_reg(input bit a, input logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input bit a, input int exp, input string tag);
    reg_addr = a;
    #5;
    chk(tag, "register readback", int'(reg_rdata), exp);
    @(posedge clk); #1;
  endtask

  // one access; starts and ends 1 ns after a rising edge with the block free
  task automatic access(input int area, input bit wr, input int wext, input bit poke,
                        input int exp_gap, input int exp_len,
                        input string gtag, input string ltag);
    int g, b, guard;
    bit fin;
    req_valid = 1'b1; req_area = 3'(area); req_write = wr;
    @(posedge clk); #1;
    req_valid = poke;
    if (poke) begin
      req_area  = (area == 3) ? 3'd4 : 3'd3;
      req_write = !wr;
    end
    g = 0; b = 0; fin = 0; guard = 0;
    while (!fin && guard < 64) begin
      ext_wait = (b < wext);
      #5;
      if (cs_n[area] == 1'b0) begin
        b++;
        if (done) fin = 1;
      end else begin
        g++;
      end
      guard++;
      @(posedge clk); #1;
    end
    req_valid = 1'b0;
    ext_wait  = 1'b0;
    if (!fin) chk(ltag, "access finished", 0, 1);
    chk(gtag, "idle cycles", g, exp_gap);
    chk(ltag, "strobe cycles", b, exp_len);
  endtask

  task automatic power_on_reset();
    cmp_en = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1 cmp_en = 1'b1;
  endtask

  initial begin
    checks = 0; fails = 0; finished = 0; cmp_en = 0;
    man_rst_n = 1'b1; reg_we = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
    req_valid = 1'b0; req_area = '0; req_write = 1'b0; ext_wait = 1'b0;
    rst_n = 1'b0;
    #1;
    power_on_reset();

    // R1 reset values and idle outputs
    reg_addr = 1'b0;
    #5;
    chk("R1", "cs_n after reset", int'(cs_n), 7'h7F);
    chk("R1", "strobes after reset", int'({rd_n, wr_n}), 3);
    chk("R1", "req_ready after reset", int'(req_ready), 1);
    @(posedge clk); #1;
    rd_chk(1'b0, 16'hFFFF, "R1");
    rd_chk(1'b1, 16'h3FF3, "R1");

    // R6 first access, R2 reset wait field of area 0 is 7
    access(0, 1'b0, 0, 1'b0, 0, 8, "R6", "R2");

    // R2 wait layout: A6=5 A5=0 A4=3 A3=2 A2=1 A0=4
    wr_reg(1'b0, 16'hA1CC);
    rd_chk(1'b0, 16'hA1CC, "R2");
    // R4 reserved bits
    wr_reg(1'b1, 16'hFFFF);
    rd_chk(1'b1, 16'hBFF3, "R4");
    // R3 codes: A0=00 A2=01 A3=10 A4=11 A5=10 A6=00, reserved written as 1
    wr_reg(1'b1, 16'h4B9C);
    rd_chk(1'b1, 16'h0B90, "R4");

    access(0, 1'b0, 0, 1'b0, 0, 5, "R5", "R2");  // same area, same direction
    access(0, 1'b1, 0, 1'b0, 1, 5, "R5", "R2");  // direction flip, code 00
    access(2, 1'b1, 0, 1'b0, 1, 2, "R3", "R2");  // code 01
    access(3, 1'b1, 0, 1'b0, 2, 3, "R3", "R2");  // code 10
    access(4, 1'b0, 0, 1'b0, 3, 4, "R3", "R2");  // code 11
    access(4, 1'b0, 0, 1'b0, 0, 4, "R5", "R2");  // repeat, no idle
    access(1, 1'b1, 0, 1'b0, 1, 1, "R3", "R3");  // area without fields
    access(6, 1'b0, 0, 1'b0, 1, 6, "R3", "R2");
    access(5, 1'b0, 3, 1'b0, 2, 1, "R3", "R7");  // WAIT ignored, select off

    // R7 select on
    wr_reg(1'b1, 16'h8B90);
    rd_chk(1'b1, 16'h8B90, "R7");
    access(5, 1'b0, 3, 1'b0, 0, 4, "R5", "R7");  // extends past zero waits
    access(6, 1'b0, 2, 1'b0, 1, 6, "R3", "R7");  // WAIT within programmed waits
    access(6, 1'b0, 8, 1'b0, 0, 9, "R5", "R7");  // WAIT outlasts programmed waits

    // R9 requests while busy are dropped and leave history alone
    access(6, 1'b0, 0, 1'b1, 0, 6, "R9", "R9");
    access(6, 1'b0, 0, 1'b0, 0, 6, "R9", "R2");

    // R8 manual reset
    man_rst_n = 1'b0;
    @(posedge clk); #1;
    man_rst_n = 1'b1;
    rd_chk(1'b0, 16'hA1CC, "R8");
    rd_chk(1'b1, 16'h8B90, "R8");
    access(2, 1'b0, 0, 1'b0, 0, 2, "R8", "R2");

    // R1 power-on reset restores registers
    power_on_reset();
    rd_chk(1'b0, 16'hFFFF, "R1");
    rd_chk(1'b1, 16'h3FF3, "R1");
    access(0, 1'b1, 0, 1'b0, 0, 8, "R6", "R2");

    repeat (2) @(posedge clk);
    #1;
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL R2 watchdog actual=running expected=complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule